// File: doc/BRIEF.md
# Execution Address Trace FIFO

This block keeps the program addresses of the last few executed instructions so that a debug controller can read them back after the core halts. While the core runs normally, each instruction-retire strobe stores the 16-bit address of that instruction in a small ring of slots. The new address overwrites the oldest slot, and the write position moves on by one.

When the debug-mode flag is high, capture stops and the ring is frozen. Every entry sits behind one shared read register. The slot shown on that register is the oldest one. Each read strobe moves the selection one slot forward and wraps at the end of the ring. A full pass therefore gives the trace in execution order and leaves the pointer where it started.

Data comes out on a 24-bit path. The 16-bit entry is left-justified in that path and the low byte is zero.

Top module: `exec_trace_fifo`

## Requirements
- R1: After reset every slot holds zero, the ring pointer selects slot 0, and rd_data reads 24'h000000.
- R2: With dbg_mode low, a cycle with retire_vld high writes retire_addr into the slot the pointer selects. The pointer then advances by one at that clock edge.
- R3: The pointer steps 0,1,2,3,4,0 and never holds a value of 5 or more, whether it is moved by captures or by reads.
- R4: When dbg_mode goes high, rd_data at once shows the oldest of the last five captured addresses.
- R5: With dbg_mode high, rd_data shows the selected slot during the cycle of a read strobe. The pointer advances at the end of that cycle, so successive reads return addresses from oldest to newest.
- R6: After five reads in debug mode the pointer selects the same slot as before the first read, so a sixth read returns the same value as the first.
- R7: While dbg_mode is high, retire_vld has no effect: no slot and no pointer value changes.
- R8: While dbg_mode is low, rd_strb has no effect on the pointer or on any slot.
- R9: rd_data carries the selected 16-bit entry in bits 23:8, and bits 7:0 are always zero.
- R10: If fewer than five addresses were captured since reset, the slots never written read back as zero, in ring order, ahead of the captured addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | Instruction retired this cycle |
| retire_addr | input | 16 | Address of the retired instruction |
| dbg_mode | input | 1 | High while the core is in debug mode |
| rd_strb | input | 1 | Read of the shared trace register |
| rd_data | output | 24 | Selected entry, left-justified, low byte zero |

## Verification
The ring is read after three kinds of capture history, and each one separates a different fault:
- A short run of two captures shows whether unwritten slots come first, as zeros, which separates a correct start position from one that begins at the newest entry.
- A run of seven captures wraps the ring, which exposes wrong wrap arithmetic and overwrite of the wrong slot.
- Long read passes of twelve or more strobes check that the pointer comes back around after five reads.

Retire pulses are also sent inside debug mode, and read strobes outside it, and the next read pass shows whether either one changed the trace.

// File: rtl/exec_trace_fifo.sv
module exec_trace_fifo #(
  parameter int DEPTH = 5,
  parameter int AW    = 16,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_vld,
  input  logic [AW-1:0] retire_addr,
  input  logic          dbg_mode,
  input  logic          rd_strb,
  output logic [DW-1:0] rd_data
);
  localparam int PW  = $clog2(DEPTH);
  localparam int PAD = DW - AW;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0][AW-1:0] slot;
  logic [PW-1:0]            ptr;

  wire capture = retire_vld && !dbg_mode;
  wire step    = capture || (rd_strb && dbg_mode);
  wire [PW-1:0] ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= ptr_nxt;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                          slot[i] <= '0;
      else if (capture && ptr == PW'(i))   slot[i] <= retire_addr;
    end
  end

  assign rd_data = {slot[ptr], {PAD{1'b0}}};

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);                                                     // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && rd_strb && ptr == LAST) |=> ptr == '0);             // R3
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode && retire_vld) |=> slot[$past(ptr)] == $past(retire_addr)); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> $stable(slot));                                      // R7
  AST_HOLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !rd_strb) |=> $stable(ptr));                         // R7
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode && !retire_vld && rd_strb) |=> $stable(ptr) && $stable(slot)); // R8
endmodule

// File: tb/tb_exec_trace_fifo.sv
`timescale 1ns/1ps
module tb_exec_trace_fifo;
  logic clk = 0, rst_n = 0, retire_vld = 0, dbg_mode = 0, rd_strb = 0;
  logic [15:0] retire_addr = '0;
  logic [23:0] rd_data;
  int checks = 0, fails = 0;
  logic [15:0] model [5];
  int mptr = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  exec_trace_fifo dut (.clk, .rst_n, .retire_vld, .retire_addr, .dbg_mode, .rd_strb, .rd_data);

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic retire(logic [15:0] a);
    retire_vld = 1; retire_addr = a;
    @(posedge clk); #1 retire_vld = 0;
    if (!dbg_mode) begin model[mptr] = a; mptr = (mptr + 1) % 5; end
  endtask

  task automatic rd(string tag);
    if (dbg_mode) begin
      exp_q.push_back({model[mptr], 8'h00});
      tag_q.push_back(tag);
    end
    rd_strb = 1;
    @(posedge clk); #1 rd_strb = 0;
    if (dbg_mode) mptr = (mptr + 1) % 5;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_strb && dbg_mode) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: unexpected read rd_data=%h expected none", rd_data);
      end else begin
        automatic logic [23:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
        check("R9 low byte", {16'h0, rd_data[7:0]}, 24'h0);
      end
    end
  end

  task automatic enter_dbg();
    @(posedge clk); #1 dbg_mode = 1;
    #1 check("R4 oldest on entry", rd_data, {model[mptr], 8'h00});
  endtask

  task automatic leave_dbg();
    @(posedge clk); #1 dbg_mode = 0;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 check("R1 reset value", rd_data, 24'h0);

    retire(16'hA001);
    retire(16'hB002);
    enter_dbg();
    for (int i = 0; i < 5; i++) rd("R10 short history");
    rd("R6 sixth read");
    retire(16'hDEAD);
    for (int i = 0; i < 5; i++) rd("R7 retire ignored in debug");
    leave_dbg();

    for (int i = 0; i < 7; i++) retire(16'h1000 + 16'(i * 3));
    enter_dbg();
    for (int i = 0; i < 5; i++) rd("R5 oldest to newest");
    for (int i = 0; i < 12; i++) rd("R3 wrap over long pass");
    leave_dbg();

    rd("R8 read outside debug");
    rd("R8 read outside debug");
    retire(16'hC0DE);
    retire(16'h7FFF);
    enter_dbg();
    for (int i = 0; i < 5; i++) rd("R2 capture after idle reads");
    leave_dbg();

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5: %0d reads unobserved, expected 0", exp_q.size());
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule